// File: doc/BRIEF.md
# Flexible-Width Dual-Port Block RAM

This block is a simple dual-port memory of 4,608 bits. The write side and the read side each pick their own word shape: 256 words of 18 bits, 512 of 9, 1,024 of 4, 2,048 of 2, or 4,096 of 1. Both sides work on the same storage. A word written at one width can be read back at another width, so a wide word can be stored once and then read out as a series of narrow slices.

Reads are synchronous with one cycle of latency. The 18-bit and 9-bit shapes reach every stored bit, parity positions included. The 4-, 2- and 1-bit shapes reach only the 4,096 data positions.

A one-bit serial preload input fills the array one bit per strobe, in a fixed order, before normal use. A test or configuration controller can load the array through it, and the block then serves as a ROM.

Top module: `flex_dpram`

## Requirements
- R1: After reset `rd_data` is zero and both ports use the 256×18 shape until a new shape is sampled.
- R2: Shape codes are 0 = 256×18, 1 = 512×9, 2 = 1024×4, 3 = 2048×2, 4 = 4096×1, and codes 5 to 7 act as 4096×1. Write data is taken from the low bits of `wr_data`. Read data sits in the low bits of `rd_data`, and the bits above the read width are zero.
- R3: In the ×18 shape, address bits 7:0 select a word. In the ×9 shape, address bits 8:1 select the word, and address bit 0 selects word bits 8:0 when it is 0 and bits 17:9 when it is 1.
- R4: The ×4, ×2 and ×1 shapes touch only the 16 data bits of a word. Those are word bits 7:0, numbered 0 to 7, and word bits 16:9, numbered 8 to 15. Word bits 8 and 17 are never changed by these shapes. The word is selected by the address shifted right by log2(16/width). The remaining low address bits select the slice, counted upward from data bit 0.
- R5: A nibble written at ×4 address a reads back at ×1 addresses 4a to 4a+3, least significant bit first.
- R6: `rd_data` changes only at the clock edge at which `rd_en` is high. While `rd_en` is low, `rd_data` holds its value even when the array is written.
- R7: When the same location is written and read in the same cycle, the read returns the value held before that write.
- R8: `wr_shape` and `rd_shape` are sampled only at an edge where `wr_en` and `rd_en` are both low. A new shape applies from the next edge. Shape inputs presented while either enable is high are ignored.
- R9: Changing a shape never alters the stored contents.
- R10: Each cycle with `pl_load` high writes `pl_bit` to flat position p, which is word p/18, bit p mod 18. After reset p starts at 0, steps by one per strobe and wraps to 0 after 4,607.
- R11: A port write presented in a cycle with `pl_load` high is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_shape | input | 3 | Requested write shape code |
| wr_addr | input | 12 | Write address in the write shape |
| wr_data | input | 18 | Write data, low-aligned |
| rd_en | input | 1 | Read strobe |
| rd_shape | input | 3 | Requested read shape code |
| rd_addr | input | 12 | Read address in the read shape |
| rd_data | output | 18 | Registered read data, low-aligned |
| pl_load | input | 1 | Serial preload strobe |
| pl_bit | input | 1 | Serial preload bit |

## Verification
Two functions can fall in the same cycle. A port write and a read can target one location together, and a port write can coincide with a preload strobe. The bench provokes the first by raising both strobes on the same ×18 address in one cycle. It expects the old word one cycle later and the new word on the following read. It provokes the second by strobing `pl_load` together with a full-ones write to a different word. It then judges both the untouched word and the preloaded bit through ordinary reads.

// File: rtl/flex_dpram_pkg.sv
package flex_dpram_pkg;
    localparam int WORDS   = 256;
    localparam int WORD_W  = 18;
    localparam int HALF_W  = WORD_W / 2;
    localparam int DATA_W  = WORD_W - 2;
    localparam int IDX_W   = $clog2(WORDS);
    localparam int ADDR_W  = IDX_W + $clog2(DATA_W);
    localparam int PBIT_W  = $clog2(WORD_W);

    typedef enum logic [2:0] {
        SHP_X18 = 3'd0,
        SHP_X9  = 3'd1,
        SHP_X4  = 3'd2,
        SHP_X2  = 3'd3,
        SHP_X1  = 3'd4
    } shape_e;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [DATA_W-1:0] dbits_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [3:0]        lane_t;

    typedef struct packed {
        idx_t  idx;
        word_t mask;
        word_t bits;
    } wr_op_t;

    // fold unused codes onto the one-bit shape
    function automatic shape_e norm_shape(logic [2:0] code);
        if (code > 3'd4) return SHP_X1;
        return shape_e'(code);
    endfunction

    // word selected by an address in a given shape
    function automatic idx_t word_idx(shape_e s, addr_t a);
        case (s)
            SHP_X18: return a[IDX_W-1:0];
            SHP_X9:  return a[IDX_W:1];
            SHP_X4:  return a[IDX_W+1:2];
            SHP_X2:  return a[IDX_W+2:3];
            default: return a[IDX_W+3:4];
        endcase
    endfunction

    // low bit of the addressed slice inside the 16 data bits
    function automatic lane_t lane_off(shape_e s, addr_t a);
        case (s)
            SHP_X4:  return {a[1:0], 2'b00};
            SHP_X2:  return {a[2:0], 1'b0};
            default: return a[3:0];
        endcase
    endfunction

    function automatic dbits_t lane_mask(shape_e s);
        case (s)
            SHP_X4:  return dbits_t'(15);
            SHP_X2:  return dbits_t'(3);
            default: return dbits_t'(1);
        endcase
    endfunction

    // place 16 data bits into word positions, skipping the parity slots
    function automatic word_t spread(dbits_t d);
        return {1'b0, d[DATA_W-1:DATA_W/2], 1'b0, d[DATA_W/2-1:0]};
    endfunction

    function automatic dbits_t gather(word_t w);
        return {w[WORD_W-2:HALF_W], w[HALF_W-2:0]};
    endfunction
endpackage

// File: rtl/flex_dpram_wmap.sv
module flex_dpram_wmap
    import flex_dpram_pkg::*;
(
    input  shape_e shape,
    input  addr_t  addr,
    input  word_t  din,
    output wr_op_t op
);
    always_comb begin
        op     = '0;
        op.idx = word_idx(shape, addr);
        case (shape)
            SHP_X18: begin
                op.mask = '1;
                op.bits = din;
            end
            SHP_X9: begin
                if (addr[0]) begin
                    op.mask = {{HALF_W{1'b1}}, {HALF_W{1'b0}}};
                    op.bits = {din[HALF_W-1:0], {HALF_W{1'b0}}};
                end else begin
                    op.mask = {{HALF_W{1'b0}}, {HALF_W{1'b1}}};
                    op.bits = {{HALF_W{1'b0}}, din[HALF_W-1:0]};
                end
            end
            default: begin
                op.mask = spread(lane_mask(shape) << lane_off(shape, addr));
                op.bits = spread((din[DATA_W-1:0] & lane_mask(shape))
                                 << lane_off(shape, addr));
            end
        endcase
    end
endmodule

// File: rtl/flex_dpram_rmap.sv
module flex_dpram_rmap
    import flex_dpram_pkg::*;
(
    input  shape_e shape,
    input  addr_t  addr,
    input  word_t  word,
    output word_t  dout
);
    always_comb begin
        case (shape)
            SHP_X18: dout = word;
            SHP_X9:  dout = addr[0] ? {{HALF_W{1'b0}}, word[WORD_W-1:HALF_W]}
                                    : {{HALF_W{1'b0}}, word[HALF_W-1:0]};
            default: dout = {2'b00, (gather(word) >> lane_off(shape, addr))
                                    & lane_mask(shape)};
        endcase
    end
endmodule

// File: rtl/flex_dpram_preload.sv
module flex_dpram_preload
    import flex_dpram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    output idx_t              p_idx,
    output logic [PBIT_W-1:0] p_bit
);
    localparam logic [PBIT_W-1:0] LAST_BIT = PBIT_W'(WORD_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            p_idx <= '0;
            p_bit <= '0;
        end else if (load) begin
            if (p_bit == LAST_BIT) begin
                p_bit <= '0;
                p_idx <= p_idx + 1'b1;
            end else begin
                p_bit <= p_bit + 1'b1;
            end
        end
    end
endmodule

// File: rtl/flex_dpram.sv
module flex_dpram
    import flex_dpram_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_shape,
    input  logic [11:0] wr_addr,
    input  logic [17:0] wr_data,
    input  logic        rd_en,
    input  logic [2:0]  rd_shape,
    input  logic [11:0] rd_addr,
    output logic [17:0] rd_data,
    input  logic        pl_load,
    input  logic        pl_bit
);
    shape_e            wr_shape_q, rd_shape_q;
    word_t             mem [WORDS];
    wr_op_t            wop;
    idx_t              p_idx;
    logic [PBIT_W-1:0] p_bit;
    idx_t              rd_idx;
    word_t             rd_word, rd_fmt;

    // shapes are latched only while both ports are idle
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_shape_q <= SHP_X18;
            rd_shape_q <= SHP_X18;
        end else if (!wr_en && !rd_en) begin
            wr_shape_q <= norm_shape(wr_shape);
            rd_shape_q <= norm_shape(rd_shape);
        end
    end

    flex_dpram_wmap i_wmap (
        .shape (wr_shape_q),
        .addr  (wr_addr),
        .din   (wr_data),
        .op    (wop)
    );

    flex_dpram_preload i_preload (
        .clk   (clk),
        .rst   (rst),
        .load  (pl_load),
        .p_idx (p_idx),
        .p_bit (p_bit)
    );

    // preload owns the array in any cycle it strobes
    always_ff @(posedge clk) begin
        if (pl_load)
            mem[p_idx][p_bit] <= pl_bit;
        else if (wr_en)
            mem[wop.idx] <= (mem[wop.idx] & ~wop.mask) | (wop.bits & wop.mask);
    end

    always_comb begin
        rd_idx  = word_idx(rd_shape_q, rd_addr);
        rd_word = mem[rd_idx];
    end

    flex_dpram_rmap i_rmap (
        .shape (rd_shape_q),
        .addr  (rd_addr),
        .word  (rd_word),
        .dout  (rd_fmt)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= rd_fmt;
    end
endmodule

// File: rtl/flex_dpram_chk.sv
module flex_dpram_chk (
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic        rd_en,
    input logic        pl_load,
    input logic [17:0] rd_data,
    input logic [2:0]  wr_shape_q,
    input logic [2:0]  rd_shape_q,
    input logic [7:0]  p_idx,
    input logic [4:0]  p_bit
);
    // R1
    rst_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_data == 18'd0));

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

    // R8
    shape_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en || rd_en) |=> ($stable(wr_shape_q) && $stable(rd_shape_q)));

    // R2
    narrow_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_shape_q == 3'd4) |=> (rd_data[17:1] == 17'd0));

    // R10
    pl_step_chk: assert property (@(posedge clk) disable iff (rst)
        (pl_load && p_bit != 5'd17) |=>
            (p_bit == $past(p_bit) + 5'd1 && p_idx == $past(p_idx)));

    // R10
    pl_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (pl_load && p_bit == 5'd17) |=>
            (p_bit == 5'd0 && p_idx == $past(p_idx) + 8'd1));

    // R10
    pl_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !pl_load |=> ($stable(p_bit) && $stable(p_idx)));
endmodule

bind flex_dpram flex_dpram_chk i_chk (.*);

// File: tb/test_flex_dpram.sv
module test_flex_dpram;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, rd_en = 1'b0, pl_load = 1'b0, pl_bit = 1'b0;
    logic [2:0]  wr_shape = 3'd0, rd_shape = 3'd0;
    logic [11:0] wr_addr = '0, rd_addr = '0;
    logic [17:0] wr_data = '0;
    logic [17:0] rd_data;

    int n_run = 0, n_fail = 0;
    int cur_w = 0, cur_r = 0, pl_ptr = 0;
    bit model [0:4607];
    bit finished = 1'b0;

    always #10 clk = ~clk;

    flex_dpram i_flex_dpram (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_shape(wr_shape), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_shape(rd_shape), .rd_addr(rd_addr), .rd_data(rd_data),
        .pl_load(pl_load), .pl_bit(pl_bit)
    );

    function automatic int wid(int s);
        return (s == 0) ? 18 : (s == 1) ? 9 : (s == 2) ? 4 : (s == 3) ? 2 : 1;
    endfunction

    // flat position (word*18 + bit) of bit j of slice a in shape s
    function automatic int fpos(int s, int a, int j);
        int di, b;
        if (s == 0) return (a % 256) * 18 + j;
        if (s == 1) return (a % 512) * 9 + j;
        di = (a * wid(s) + j) % 4096;
        b  = di % 16;
        return (di / 16) * 18 + ((b < 8) ? b : b + 1);
    endfunction

    function automatic logic [17:0] expect_rd(int a);
        logic [17:0] e = '0;
        for (int j = 0; j < wid(cur_r); j++) e[j] = model[fpos(cur_r, a, j)];
        return e;
    endfunction

    task automatic chk(input logic [17:0] act, input logic [17:0] exp, input string tag);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_shapes(input int w, input int r);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        wr_shape = w[2:0]; rd_shape = r[2:0];
        @(posedge clk);
        cur_w = (w > 4) ? 4 : w;
        cur_r = (r > 4) ? 4 : r;
    endtask

    task automatic write_op(input int a, input logic [17:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a[11:0]; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        for (int j = 0; j < wid(cur_w); j++) model[fpos(cur_w, a, j)] = d[j];
    endtask

    task automatic read_chk(input int a, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a[11:0];
        @(negedge clk);
        chk(rd_data, expect_rd(a), tag);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        chk(rd_data, 18'd0, "R1 rd_data after reset");
        write_op(3, 18'h2D5A1);
        read_chk(3, "R1 default shape is x18");
    endtask

    task automatic t_preload;
        for (int p = 0; p < 4608; p++) begin
            @(negedge clk);
            pl_load = 1'b1;
            pl_bit  = ((p * 5 + p / 7) % 3) == 0;
            model[p] = pl_bit;
        end
        @(negedge clk);
        pl_load = 1'b0;
        pl_ptr = 0;
        read_chk(0, "R10 preload word 0");
        read_chk(1, "R10 preload word 1");
        read_chk(100, "R10 preload word 100");
        read_chk(255, "R10 preload last word");
    endtask

    task automatic t_prio;
        @(negedge clk);
        pl_load = 1'b1; pl_bit = ~model[pl_ptr];
        wr_en = 1'b1; wr_addr = 12'd50; wr_data = '1;
        @(negedge clk);
        model[pl_ptr] = pl_bit;
        pl_load = 1'b0; wr_en = 1'b0;
        pl_ptr++;
        read_chk(50, "R11 write dropped during preload");
        read_chk(0, "R10 pointer wrapped to 0");
    endtask

    task automatic t_x18;
        write_op(200, 18'h3C3A5);
        write_op(456, 18'h15AA7);
        read_chk(200, "R3 x18 word");
        read_chk(200, "R3 x18 upper address ignored");
    endtask

    task automatic t_x9;
        set_shapes(1, 0);
        write_op(6, 18'h1A5);
        write_op(7, 18'h0C3);
        read_chk(3, "R3 x9 halves in x18 word");
        chk(rd_data, {9'h0C3, 9'h1A5}, "R3 x9 literal placement");
    endtask

    task automatic t_cross;
        set_shapes(2, 4);
        write_op(37, 18'h0000B);
        for (int k = 0; k < 4; k++) read_chk(148 + k, "R5 x4 read back at x1");
        read_chk(150, "R5 x1 slice 2");
        chk(rd_data, 18'd0, "R5 x1 slice 2 literal");
        set_shapes(2, 3);
        read_chk(74, "R4 x2 low pair");
        read_chk(75, "R4 x2 high pair");
        chk(rd_data, 18'h2, "R2 x2 upper bits zero");
    endtask

    task automatic t_parity;
        set_shapes(0, 0);
        write_op(9, 18'h3FFFF);
        set_shapes(4, 0);
        for (int k = 0; k < 16; k++) write_op(144 + k, 18'd0);
        set_shapes(0, 0);
        read_chk(9, "R4 narrow writes skip parity");
        chk(rd_data, 18'h20100, "R4 parity bits 17 and 8 kept");
    endtask

    task automatic t_keep;
        set_shapes(0, 1);
        read_chk(200, "R9 contents after shape change, low half");
        read_chk(201, "R9 contents after shape change, high half");
        set_shapes(0, 0);
        read_chk(100, "R9 preload word intact");
    endtask

    task automatic t_unused_code;
        set_shapes(5, 0);
        write_op(300, 18'h3FFFF);
        set_shapes(0, 0);
        read_chk(18, "R2 code 5 acts as x1");
    endtask

    task automatic t_shape_ignore;
        set_shapes(0, 0);
        write_op(5, 18'd0);
        write_op(6, 18'd0);
        @(negedge clk);
        wr_en = 1'b1; wr_shape = 3'd4; wr_addr = 12'd5; wr_data = '1;
        @(negedge clk);
        wr_addr = 12'd6;
        @(negedge clk);
        wr_en = 1'b0; wr_shape = 3'd0;
        for (int j = 0; j < 18; j++) begin
            model[5 * 18 + j] = 1'b1;
            model[6 * 18 + j] = 1'b1;
        end
        read_chk(5, "R8 shape ignored while enabled, first");
        read_chk(6, "R8 shape ignored while enabled, second");
        chk(rd_data, 18'h3FFFF, "R8 full word written");
    endtask

    task automatic t_same_cycle;
        write_op(20, 18'h12345);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'd20; wr_data = 18'h0ABCD;
        rd_en = 1'b1; rd_addr = 12'd20;
        @(negedge clk);
        chk(rd_data, 18'h12345, "R7 same-cycle read returns old data");
        wr_en = 1'b0; rd_en = 1'b0;
        for (int j = 0; j < 18; j++) model[20 * 18 + j] = wr_data[j];
        read_chk(20, "R7 later read returns new data");
    endtask

    task automatic t_hold;
        write_op(20, 18'h00F0F);
        @(negedge clk);
        chk(rd_data, 18'h0ABCD, "R6 rd_data held while rd_en low");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_preload();
        t_prio();
        t_x18();
        t_x9();
        t_cross();
        t_parity();
        t_keep();
        t_unused_code();
        t_shape_ignore();
        t_same_cycle();
        t_hold();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule